// File: doc/BRIEF.md
# Pulse-Frequency Buck Gate Sequencer

This block is the digital controller of a synchronous step-down converter that runs in discontinuous conduction and regulates by pulse frequency. A comparator outside the block reports whether the converter output has sagged below its target. The sequencer looks at that comparator only on the ticks of a programmable clock divider. When a tick finds the output low, the sequencer runs one fixed pattern. It first drives the high-side switch for a set number of fast-clock cycles. It then holds both switches off for a set guard interval. Last, it drives the low-side switch.

The low-side on-time is not measured from the inductor current. It is looked up from four programmed entries, chosen by the two most significant bits of the reference code. Each entry is meant to hold a value close to the high-side width scaled by (supply − output)/output for that band of output voltages, so the low-side switch opens near the point where the inductor current reaches zero. Dropping the enable input silences both gate outputs at once. A supervisor can use this to park the converter while the load's energy is being measured.

Top module: `pfm_pulse_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, both gate outputs are low.
- R2: The comparator is sampled only on divider ticks. With the divider ratio set to D, ticks fall every D+1 fast-clock cycles. Counting starts when reset is released or enable is raised, so the first high-side cycle is visible D+1 cycles after enable rises.
- R3: A tick that sees the comparator high (output below target) starts a sequence. The high-side output is then high for exactly `hs_width` cycles, starting in the next cycle. A programmed width of 0 acts as 1.
- R4: After the high-side pulse, both outputs stay low for exactly `dead_width` cycles. A programmed 0 acts as 1.
- R5: The low-side output is then high for the table entry picked by `ref_code[REF_W-1:REF_W-2]`. Entry k sits at bits `ls_width_tbl[k*CNT_W +: CNT_W]`, and an entry of 0 acts as 1.
- R6: The two gate outputs are never high in the same cycle.
- R7: Comparator requests made while a sequence is running are neither acted on nor remembered. The next sequence can only start on a tick after the low-side pulse has ended. With D = 0 and the comparator held high, exactly one idle cycle separates sequences.
- R8: When enable is low at a clock edge, both outputs are low in the next cycle, and the running sequence is abandoned.
- R9: The three widths and the reference code are captured on the tick that starts a sequence. Changing them during the sequence does not alter that sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast timing clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Converter run enable; low forces both gates off |
| div_ratio | input | DIV_W | Comparator sampling divider; tick every div_ratio+1 cycles |
| cmp_low | input | 1 | Comparator: high when output is below the reference |
| ref_code | input | REF_W | Digital reference code; top two bits choose the low-side width |
| hs_width | input | CNT_W | High-side on-time in fast-clock cycles |
| dead_width | input | CNT_W | Guard interval between high-side and low-side pulses |
| ls_width_tbl | input | 4*CNT_W | Four packed low-side on-times, entry k at bits k*CNT_W |
| hs_on | output | 1 | High-side switch gate |
| ls_on | output | 1 | Low-side switch gate |

## Verification
Several properties are checked on every cycle: the two gates are never on together, a low enable clears both gates one cycle later, a high-side pulse only starts after an enabled comparator request, and a guard cycle always separates the gates. Other behaviour depends on counting and can only be shown through the bench's scenarios. This covers the pulse lengths, the guard length and the table entry chosen by the reference bits. It also covers the divider phase at which a request is first seen, the rule that mid-sequence requests are forgotten, and the freezing of the settings at the start of a sequence. The bench shows these with directed runs and with a per-cycle reference model under random settings.

// File: rtl/pfm_pkg.sv
package pfm_pkg;

    // Number of low-side on-time entries and the reference bits that pick one
    localparam int NUM_LS   = 4;
    localparam int LS_SEL_W = $clog2(NUM_LS);

    // Phases of one switching sequence
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HIGH = 2'd1,
        PH_DEAD = 2'd2,
        PH_LOW  = 2'd3
    } phase_e;

    // Gate drive pair
    typedef struct packed {
        logic hs;
        logic ls;
    } gate_t;

    // Gate levels that each phase implies
    function automatic gate_t gate_of(phase_e p);
        gate_t g;
        g.hs = (p == PH_HIGH);
        g.ls = (p == PH_LOW);
        return g;
    endfunction

endpackage

// File: rtl/pfm_tick_div.sv
module pfm_tick_div #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic [DIV_W-1:0] ratio,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;
    logic             wrap;

    // A tick is due once the count reaches the ratio (ratio 0: every cycle)
    assign wrap = (cnt_q >= ratio);
    assign tick = enable && wrap;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            cnt_q <= '0;
        end else if (wrap) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/pfm_ls_select.sv
module pfm_ls_select
    import pfm_pkg::*;
#(
    parameter int REF_W = 7,
    parameter int CNT_W = 6
) (
    input  logic [REF_W-1:0]        ref_code,
    input  logic [NUM_LS*CNT_W-1:0] width_tbl,
    output logic [CNT_W-1:0]        ls_width
);

    logic [CNT_W-1:0]    entry [NUM_LS];
    logic [LS_SEL_W-1:0] band;

    // Unpack the flat table into entries
    for (genvar g = 0; g < NUM_LS; g++) begin : g_entry
        assign entry[g] = width_tbl[g*CNT_W +: CNT_W];
    end

    // The most significant reference bits name the voltage band
    assign band     = ref_code[REF_W-1 -: LS_SEL_W];
    assign ls_width = entry[band];

endmodule

// File: rtl/pfm_phase_fsm.sv
module pfm_phase_fsm
    import pfm_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             tick,
    input  logic             cmp_low,
    input  logic [CNT_W-1:0] hs_width,
    input  logic [CNT_W-1:0] dead_width,
    input  logic [CNT_W-1:0] ls_width,
    output logic             hs_on,
    output logic             ls_on
);

    typedef logic [CNT_W-1:0] cnt_t;
    localparam cnt_t ONE = cnt_t'(1);

    // A zero-length setting is stretched to one cycle
    function automatic cnt_t at_least_one(cnt_t w);
        return (w == '0) ? ONE : w;
    endfunction

    phase_e phase_q, phase_d;
    cnt_t   cnt_q, cnt_d;
    cnt_t   hs_len_q, hs_len_d;
    cnt_t   dead_len_q, dead_len_d;
    cnt_t   ls_len_q, ls_len_d;
    gate_t  gate_q, gate_d;
    logic   start;

    assign start = tick && cmp_low;

    always_comb begin
        phase_d    = phase_q;
        cnt_d      = cnt_q;
        hs_len_d   = hs_len_q;
        dead_len_d = dead_len_q;
        ls_len_d   = ls_len_q;
        unique case (phase_q)
            PH_IDLE: begin
                if (start) begin
                    phase_d    = PH_HIGH;
                    cnt_d      = ONE;
                    hs_len_d   = at_least_one(hs_width);
                    dead_len_d = at_least_one(dead_width);
                    ls_len_d   = at_least_one(ls_width);
                end
            end
            PH_HIGH: begin
                if (cnt_q >= hs_len_q) begin
                    phase_d = PH_DEAD;
                    cnt_d   = ONE;
                end else begin
                    cnt_d = cnt_q + ONE;
                end
            end
            PH_DEAD: begin
                if (cnt_q >= dead_len_q) begin
                    phase_d = PH_LOW;
                    cnt_d   = ONE;
                end else begin
                    cnt_d = cnt_q + ONE;
                end
            end
            PH_LOW: begin
                if (cnt_q >= ls_len_q) begin
                    phase_d = PH_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + ONE;
                end
            end
            default: begin
                phase_d = PH_IDLE;
                cnt_d   = '0;
            end
        endcase
        // Disable overrides any phase
        if (!enable) begin
            phase_d = PH_IDLE;
            cnt_d   = '0;
        end
        gate_d = gate_of(phase_d);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= PH_IDLE;
            cnt_q      <= '0;
            hs_len_q   <= ONE;
            dead_len_q <= ONE;
            ls_len_q   <= ONE;
            gate_q     <= '0;
        end else begin
            phase_q    <= phase_d;
            cnt_q      <= cnt_d;
            hs_len_q   <= hs_len_d;
            dead_len_q <= dead_len_d;
            ls_len_q   <= ls_len_d;
            gate_q     <= gate_d;
        end
    end

    assign hs_on = gate_q.hs;
    assign ls_on = gate_q.ls;

endmodule

// File: rtl/pfm_pulse_seq.sv
module pfm_pulse_seq
    import pfm_pkg::*;
#(
    parameter int DIV_W = 4,
    parameter int REF_W = 7,
    parameter int CNT_W = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    enable,
    input  logic [DIV_W-1:0]        div_ratio,
    input  logic                    cmp_low,
    input  logic [REF_W-1:0]        ref_code,
    input  logic [CNT_W-1:0]        hs_width,
    input  logic [CNT_W-1:0]        dead_width,
    input  logic [NUM_LS*CNT_W-1:0] ls_width_tbl,
    output logic                    hs_on,
    output logic                    ls_on
);

    logic             tick;
    logic [CNT_W-1:0] ls_width;

    pfm_tick_div #(.DIV_W(DIV_W)) i_div (
        .clk    (clk),
        .rst    (rst),
        .enable (enable),
        .ratio  (div_ratio),
        .tick   (tick)
    );

    pfm_ls_select #(.REF_W(REF_W), .CNT_W(CNT_W)) i_sel (
        .ref_code  (ref_code),
        .width_tbl (ls_width_tbl),
        .ls_width  (ls_width)
    );

    pfm_phase_fsm #(.CNT_W(CNT_W)) i_fsm (
        .clk        (clk),
        .rst        (rst),
        .enable     (enable),
        .tick       (tick),
        .cmp_low    (cmp_low),
        .hs_width   (hs_width),
        .dead_width (dead_width),
        .ls_width   (ls_width),
        .hs_on      (hs_on),
        .ls_on      (ls_on)
    );

endmodule

// File: rtl/pfm_pulse_seq_chk.sv
module pfm_pulse_seq_chk (
    input logic clk,
    input logic rst,
    input logic enable,
    input logic cmp_low,
    input logic hs_on,
    input logic ls_on
);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!hs_on && !ls_on));

    assert_no_overlap_R6: assert property (@(posedge clk) disable iff (rst)
        !(hs_on && ls_on));

    assert_disable_clears_R8: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!hs_on && !ls_on));

    assert_hs_needs_request_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(hs_on) |-> ($past(cmp_low) && $past(enable)));

    assert_guard_after_hs_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(hs_on) |-> !ls_on);

    assert_ls_after_guard_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(ls_on) |-> !$past(hs_on));

endmodule

bind pfm_pulse_seq pfm_pulse_seq_chk i_pfm_chk (
    .clk     (clk),
    .rst     (rst),
    .enable  (enable),
    .cmp_low (cmp_low),
    .hs_on   (hs_on),
    .ls_on   (ls_on)
);

// File: tb/test_pfm_pulse_seq.sv
module test_pfm_pulse_seq;

    localparam int CW = 6;
    localparam int DW = 4;
    localparam int RW = 7;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          enable = 1'b0;
    logic          cmp_low = 1'b0;
    logic [DW-1:0] div_ratio = '0;
    logic [RW-1:0] ref_code = '0;
    logic [CW-1:0] hs_width = 6'd3;
    logic [CW-1:0] dead_width = 6'd2;
    logic [4*CW-1:0] ls_tbl = {6'd7, 6'd5, 6'd3, 6'd2};
    logic          hs_on, ls_on;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    pfm_pulse_seq #(.DIV_W(DW), .REF_W(RW), .CNT_W(CW)) i_pfm_pulse_seq (
        .clk          (clk),
        .rst          (rst),
        .enable       (enable),
        .div_ratio    (div_ratio),
        .cmp_low      (cmp_low),
        .ref_code     (ref_code),
        .hs_width     (hs_width),
        .dead_width   (dead_width),
        .ls_width_tbl (ls_tbl),
        .hs_on        (hs_on),
        .ls_on        (ls_on)
    );

    always #4 clk = ~clk;

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    function automatic int floor1(int w);
        return (w == 0) ? 1 : w;
    endfunction

    function automatic int tbl_entry(logic [4*CW-1:0] t, logic [RW-1:0] r);
        int s;
        s = int'(r[RW-1 -: 2]);
        return int'(t[s*CW +: CW]);
    endfunction

    // Per-cycle reference model written from the requirements
    int m_st = 0, m_cnt = 0, m_div = 0, m_h = 1, m_d = 1, m_l = 1;
    bit m_tick;
    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_div = 0; m_cnt = 0;
        end else begin
            m_tick = enable && (m_div >= int'(div_ratio));
            if (!enable || m_div >= int'(div_ratio)) m_div = 0;
            else m_div = m_div + 1;
            if (!enable) m_st = 0;
            else begin
                case (m_st)
                    0: if (m_tick && cmp_low) begin
                        m_st = 1; m_cnt = 1;
                        m_h = floor1(int'(hs_width));
                        m_d = floor1(int'(dead_width));
                        m_l = floor1(tbl_entry(ls_tbl, ref_code));
                    end
                    1: if (m_cnt >= m_h) begin m_st = 2; m_cnt = 1; end else m_cnt++;
                    2: if (m_cnt >= m_d) begin m_st = 3; m_cnt = 1; end else m_cnt++;
                    default: if (m_cnt >= m_l) begin m_st = 0; m_cnt = 0; end else m_cnt++;
                endcase
            end
        end
    end

    always @(negedge clk) begin
        check((hs_on == (m_st == 1)) && (ls_on == (m_st == 3)),
              "R2 R3 R4 R5 R7 R9 per-cycle gates {hs,ls}",
              int'({hs_on, ls_on}), int'({m_st == 1, m_st == 3}));
        check(!(hs_on && ls_on), "R6 gates overlap", int'({hs_on, ls_on}), 0);
    end

    // Measure one full sequence plus the idle gap to the next high-side pulse
    task automatic measure(output int h, output int d, output int l, output int gap);
        int t = 0;
        while (!hs_on && t < 200) begin @(negedge clk); t++; end
        h = 0;   while (hs_on) begin h++; @(negedge clk); end
        d = 0;   while (!hs_on && !ls_on && d < 200) begin d++; @(negedge clk); end
        l = 0;   while (ls_on) begin l++; @(negedge clk); end
        gap = 0; while (!hs_on && gap < 200) begin gap++; @(negedge clk); end
    endtask

    task automatic park();
        enable = 1'b0; cmp_low = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        int n, h, d, l, gap, hits;
        void'($urandom(32'd5127));
        repeat (4) @(negedge clk);
        check(!hs_on && !ls_on, "R1 outputs during reset", int'({hs_on, ls_on}), 0);
        rst = 1'b0;
        @(negedge clk);
        check(!hs_on && !ls_on, "R1 outputs after reset", int'({hs_on, ls_on}), 0);

        // R2: first high-side cycle appears div_ratio+1 cycles after enable
        div_ratio = 4'd3; cmp_low = 1'b1; enable = 1'b1;
        n = 0;
        do begin @(negedge clk); n++; end while (!hs_on && n < 50);
        check(n == 4, "R2 first pulse delay with divider 3", n, 4);
        park();

        // R3 R4 R5 R7: widths for each band, zero settings floored
        for (int k = 0; k < 4; k++) begin
            hs_width   = (k == 2) ? 6'd0 : 6'(k + 2);
            dead_width = (k == 2) ? 6'd0 : 6'(k + 1);
            ref_code   = {2'(k), 5'($urandom)};
            div_ratio  = '0;
            enable = 1'b1; cmp_low = 1'b1;
            measure(h, d, l, gap);
            check(h == floor1(int'(hs_width)), "R3 high-side width", h, floor1(int'(hs_width)));
            check(d == floor1(int'(dead_width)), "R4 dead gap", d, floor1(int'(dead_width)));
            check(l == tbl_entry(ls_tbl, ref_code), "R5 low-side width from band", l,
                  tbl_entry(ls_tbl, ref_code));
            check(gap == 1, "R7 idle cycles between back-to-back sequences", gap, 1);
            park();
        end

        // R9: settings changed mid-sequence do not affect it
        hs_width = 6'd4; dead_width = 6'd2; ref_code = 7'b0100000;
        enable = 1'b1; cmp_low = 1'b1;
        n = 0;
        while (!hs_on && n < 50) begin @(negedge clk); n++; end
        hs_width = 6'd9; dead_width = 6'd6; ref_code = 7'b1100000;
        h = 0; while (hs_on) begin h++; @(negedge clk); end
        d = 0; while (!hs_on && !ls_on && d < 100) begin d++; @(negedge clk); end
        l = 0; while (ls_on) begin l++; @(negedge clk); end
        check(h == 4, "R9 high width frozen", h, 4);
        check(d == 2, "R9 dead width frozen", d, 2);
        check(l == 3, "R9 band frozen at start", l, 3);
        park();

        // R7: a request during the sequence is not remembered
        hs_width = 6'd2; dead_width = 6'd1; ref_code = 7'b0000000;
        enable = 1'b1; cmp_low = 1'b1;
        n = 0;
        while (!hs_on && n < 50) begin @(negedge clk); n++; end
        cmp_low = 1'b0;
        while (hs_on) @(negedge clk);
        cmp_low = 1'b1;
        @(negedge clk);
        cmp_low = 1'b0;
        while (ls_on || hs_on) @(negedge clk);
        hits = 0;
        repeat (10) begin @(negedge clk); if (hs_on) hits++; end
        check(hits == 0, "R7 mid-sequence request ignored", hits, 0);
        park();

        // R8: disable during high-side and low-side phases
        hs_width = 6'd8; dead_width = 6'd1; ref_code = 7'b1000000;
        enable = 1'b1; cmp_low = 1'b1;
        n = 0;
        while (!hs_on && n < 50) begin @(negedge clk); n++; end
        @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        check(!hs_on && !ls_on, "R8 disable during high-side", int'({hs_on, ls_on}), 0);
        hs_width = 6'd1; enable = 1'b1;
        n = 0;
        while (!ls_on && n < 50) begin @(negedge clk); n++; end
        enable = 1'b0;
        @(negedge clk);
        check(!hs_on && !ls_on, "R8 disable during low-side", int'({hs_on, ls_on}), 0);
        hits = 0;
        repeat (6) begin @(negedge clk); if (hs_on || ls_on) hits++; end
        check(hits == 0, "R8 held disabled with request", hits, 0);

        // Random phase checked by the per-cycle model
        for (int c = 0; c < 4000; c++) begin
            if (c % 256 == 0) begin
                div_ratio  = DW'($urandom % 4);
                hs_width   = CW'($urandom % 6);
                dead_width = CW'($urandom % 4);
                ls_tbl     = 24'($urandom);
            end
            if ($urandom % 8 == 0) ref_code = RW'($urandom);
            cmp_low = ($urandom % 4 == 0);
            enable  = ($urandom % 60 != 0);
            @(negedge clk);
        end

        done = 1'b1;
        report();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R2 watchdog: actual=running expected=finished");
            report();
            $finish;
        end
    end

endmodule